// File: doc/BRIEF.md
# Condition-Truncated Vector Loop Controller

This block steps a vector operation through elements 0 to VL-1, strictly in ascending order. The execution unit returns each element's result together with a small condition field. The controller holds that result in a single-entry buffer until the element's condition test is decided. It then either commits the result through a write port or drops it. The test picks one bit of the condition field and compares it with an invert flag. When the bit equals the flag, the element fails. The loop stops at the first failure, no later element is requested or written, and a shortened vector length is reported with a one-cycle done pulse.

The shortened length is the number of elements actually written. In the default, exclusive form, the failing element is dropped and the length equals its index. Because of this, a failure on element 0 legally yields a length of zero. A compare-only variant always tests the equality bit of the condition field. Only that variant may also choose the inclusive form, where the failing element is still written and counted. If no element fails, the length is returned unchanged: the length only ever shrinks because a test failed.

Top module: `ffirst_vec_ctrl`

## Requirements
- R1: Elements are requested and written in ascending index order starting at 0, and each written index is one more than the previous write of the same run.
- R2: An element fails when condition bit `bit_sel` equals `inv`. With `inv`=0 the element passes only if that bit is 1, and with `inv`=1 it passes only if that bit is 0.
- R3: After the first failing element, no further element is requested or written in that run, and no write occurs after done until a new run is started.
- R4: With the exclusive form, `new_vl` equals the failing element's index and the failing element is not written.
- R5: With the inclusive form, `new_vl` equals the failing index plus one and the failing element is written, including when the failure is on the last element.
- R6: A failure on element 0 in exclusive form gives `new_vl` = 0 with a normal done pulse. A start with length 0 gives done one cycle later with `new_vl` = 0.
- R7: If no element fails, `new_vl` equals the started length and done follows the write of element VL-1. `new_vl` never exceeds the started length.
- R8: With `nocr`=1, condition bit 2 (the equality bit) is tested whatever `bit_sel` holds. With `nocr`=0, `incl` is ignored and the exclusive form applies.
- R9: A result accepted at a clock edge (`elem_req` and `elem_valid` both high) is presented on `wr_en`/`wr_idx`/`wr_data` in the following cycle if it commits. Done and `new_vl` appear one cycle after the deciding cycle. Done lasts one cycle and `new_vl` holds until the next completion.
- R10: A start while `busy` is high is ignored and leaves the running loop's length, test and outcome unchanged.
- R11: During and right after reset, `busy`, `done`, `wr_en` and `elem_req` are 0 and `new_vl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| start_vl | input | VL_W | Vector length of the run |
| bit_sel | input | clog2(CR_W) | Index of the condition bit to test when `nocr`=0 |
| inv | input | 1 | Failure value of the tested bit |
| incl | input | 1 | Inclusive form; honoured only with `nocr`=1 |
| nocr | input | 1 | Compare-only variant: test the equality bit |
| elem_req | output | 1 | Controller can accept the element at `elem_idx` |
| elem_idx | output | VL_W | Index of the element requested |
| elem_valid | input | 1 | Result and condition for `elem_idx` are present |
| elem_data | input | DATA_W | Element result |
| elem_cond | input | CR_W | Element condition field |
| wr_en | output | 1 | Commit the held result |
| wr_idx | output | VL_W | Element index being committed |
| wr_data | output | DATA_W | Result being committed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| new_vl | output | VL_W | Resulting vector length, valid from done |

## Verification
An element taken at edge N is decided during the cycle after N. Its write shows up in that cycle, and done and the new length follow at edge N+1. A zero-length start raises done at the very next edge. A behavioural model in the bench applies these latencies at every rising edge. All design outputs are compared with the model on each falling edge, half a cycle after the edge that changed them. On top of that, every run's final length and its logged write indices are checked against a first-failure search over the condition table, written directly from the requirements. Stall patterns on `elem_valid` move acceptance edges around to confirm the timing holds under back-pressure.

// File: rtl/ffirst_vec_ctrl.sv
`timescale 1ns/1ps
module ffirst_vec_ctrl #(
  parameter int DATA_W = 32,
  parameter int VL_W   = 7,
  parameter int CR_W   = 4,
  parameter int EQ_IDX = 2
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [VL_W-1:0]         start_vl,
  input  logic [$clog2(CR_W)-1:0] bit_sel,
  input  logic                    inv,
  input  logic                    incl,
  input  logic                    nocr,
  output logic                    elem_req,
  output logic [VL_W-1:0]         elem_idx,
  input  logic                    elem_valid,
  input  logic [DATA_W-1:0]       elem_data,
  input  logic [CR_W-1:0]         elem_cond,
  output logic                    wr_en,
  output logic [VL_W-1:0]         wr_idx,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    busy,
  output logic                    done,
  output logic [VL_W-1:0]         new_vl
);
  localparam int SEL_W = $clog2(CR_W);
  localparam logic [VL_W-1:0] VL_ONE = VL_W'(1);

  logic              busy_q, hold_q, inv_q, incl_q, done_q;
  logic [SEL_W-1:0]  sel_q;
  logic [VL_W-1:0]   vl_q, idx_q, new_vl_q;
  logic [DATA_W-1:0] data_q;
  logic [CR_W-1:0]   cond_q;
  logic              launch, take, fail, last, term;

  assign launch = start & ~busy_q;
  assign take   = busy_q & ~hold_q & elem_valid;
  assign fail   = hold_q & (cond_q[sel_q] == inv_q);
  assign last   = idx_q == vl_q - VL_ONE;
  assign term   = hold_q & (fail | last);

  assign elem_req = busy_q & ~hold_q;
  assign elem_idx = idx_q;
  assign wr_en    = hold_q & (~fail | incl_q);
  assign wr_idx   = idx_q;
  assign wr_data  = data_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign new_vl   = new_vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      hold_q   <= 1'b0;
      done_q   <= 1'b0;
      inv_q    <= 1'b0;
      incl_q   <= 1'b0;
      sel_q    <= '0;
      vl_q     <= '0;
      idx_q    <= '0;
      new_vl_q <= '0;
      data_q   <= '0;
      cond_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        vl_q   <= start_vl;
        idx_q  <= '0;
        inv_q  <= inv;
        incl_q <= incl & nocr;
        sel_q  <= nocr ? SEL_W'(EQ_IDX) : bit_sel;
        if (start_vl == '0) begin
          done_q   <= 1'b1;
          new_vl_q <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end
      if (take) begin
        hold_q <= 1'b1;
        data_q <= elem_data;
        cond_q <= elem_cond;
      end
      if (hold_q) begin
        hold_q <= 1'b0;
        if (term) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          new_vl_q <= fail ? idx_q + VL_W'(incl_q) : vl_q;
        end else begin
          idx_q <= idx_q + VL_ONE;
        end
      end
    end
  end
endmodule

module ffirst_vec_ctrl_chk #(
  parameter int VL_W = 7
)(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VL_W-1:0] start_vl,
  input logic            busy,
  input logic            wr_en,
  input logic [VL_W-1:0] wr_idx,
  input logic            done,
  input logic [VL_W-1:0] new_vl
);
  logic [VL_W-1:0] vl_cap, wcnt;
  logic            closed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_cap <= '0;
      wcnt   <= '0;
      closed <= 1'b1;
    end else begin
      if (wr_en) wcnt <= wcnt + VL_W'(1);
      if (done) closed <= 1'b1;
      if (start && !busy) begin
        vl_cap <= start_vl;
        wcnt   <= '0;
        closed <= 1'b0;
      end
    end
  end

  assert_write_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == wcnt);
  assert_no_write_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !closed && busy);
  assert_len_counts_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_vl == wcnt);
  assert_len_never_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_vl <= vl_cap);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
endmodule

bind ffirst_vec_ctrl ffirst_vec_ctrl_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_vl(start_vl), .busy(busy),
  .wr_en(wr_en), .wr_idx(wr_idx), .done(done), .new_vl(new_vl)
);

// File: tb/ffirst_vec_ctrl_bench.sv
`timescale 1ns/1ps
module ffirst_vec_ctrl_bench;
  localparam int DW = 32;
  localparam int VW = 7;
  localparam int CW = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] start_vl = '0;
  logic [SW-1:0] bit_sel = '0;
  logic          inv = 1'b0, incl = 1'b0, nocr = 1'b0;
  logic          elem_req, elem_valid = 1'b0;
  logic [VW-1:0] elem_idx;
  logic [DW-1:0] elem_data = '0;
  logic [CW-1:0] elem_cond = '0;
  logic          wr_en, busy, done;
  logic [VW-1:0] wr_idx, new_vl;
  logic [DW-1:0] wr_data;

  ffirst_vec_ctrl u_ffirst_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_vl(start_vl), .bit_sel(bit_sel),
    .inv(inv), .incl(incl), .nocr(nocr), .elem_req(elem_req), .elem_idx(elem_idx),
    .elem_valid(elem_valid), .elem_data(elem_data), .elem_cond(elem_cond),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy), .done(done),
    .new_vl(new_vl)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [CW-1:0] cond_tab [0:127];
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  int wlog[$];

  bit mb = 0, mh = 0, mdone = 0, minv = 0, mincl = 0;
  int mvl = 0, midx = 0, mnvl = 0, msel = 0;
  logic [CW-1:0] mcond = '0;
  logic [DW-1:0] mdata = '0;

  always @(posedge clk) begin : model
    bit ob, f, lst;
    if (!rst_n) begin
      mb = 0; mh = 0; mdone = 0; mnvl = 0; midx = 0; mvl = 0;
    end else begin
      ob = mb;
      mdone = 0;
      if (mh) begin
        f = (mcond[msel] == minv);
        lst = (midx == mvl - 1);
        mh = 0;
        if (f || lst) begin
          mb = 0; mdone = 1;
          mnvl = f ? midx + (mincl ? 1 : 0) : mvl;
        end else midx++;
      end else if (mb && elem_valid) begin
        mh = 1; mcond = elem_cond; mdata = elem_data;
      end
      if (start && !ob) begin
        mvl = int'(start_vl); midx = 0; minv = inv; mincl = incl && nocr;
        msel = nocr ? 2 : int'(bit_sel);
        if (start_vl == '0) begin mdone = 1; mnvl = 0; end
        else mb = 1;
      end
    end
  end

  always @(posedge clk) if (rst_n && wr_en) wlog.push_back(int'(wr_idx));

  always @(negedge clk) begin : compare
    bit ok, exp_req, exp_wr;
    if (rst_n) begin
      exp_req = mb && !mh;
      exp_wr = mh && (!(mcond[msel] == minv) || mincl);
      ok = (busy == mb) && (elem_req == exp_req) && (wr_en == exp_wr) && (done == mdone);
      if (exp_req && elem_idx != VW'(midx)) ok = 0;
      if (exp_wr && (wr_idx != VW'(midx) || wr_data != mdata)) ok = 0;
      if (mdone && new_vl != VW'(mnvl)) ok = 0;
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R9 cycle %0d: busy=%b req=%b wr=%b idx=%0d done=%b vl=%0d expected busy=%b req=%b wr=%b idx=%0d done=%b vl=%0d",
                 cyc, busy, elem_req, wr_en, wr_idx, done, new_vl, mb, exp_req, exp_wr, midx, mdone, mnvl);
      end
    end
  end

  always @(negedge clk) begin : driver
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    elem_valid = elem_req && (!stall_en || lfsr[0]);
    elem_data = 32'hA000 + 32'(elem_idx);
    elem_cond = cond_tab[elem_idx];
  end

  task automatic check(bit c, string tag, string what, int act, int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_vl(int vl, int sel, bit iv, bit ic, bit nc);
    int b = nc ? 2 : sel;
    for (int i = 0; i < vl; i++)
      if (cond_tab[i][b] == iv) return i + ((ic && nc) ? 1 : 0);
    return vl;
  endfunction

  task automatic fill(logic [CW-1:0] v);
    for (int i = 0; i < 128; i++) cond_tab[i] = v;
  endtask

  task automatic run(string tag, int vl, int sel, bit iv, bit ic, bit nc, int busy_start_at);
    int expv, t;
    bit seq;
    expv = ref_vl(vl, sel, iv, ic, nc);
    wlog.delete();
    @(negedge clk);
    start = 1; start_vl = VW'(vl); bit_sel = SW'(sel); inv = iv; incl = ic; nocr = nc;
    @(negedge clk);
    start = 0; start_vl = '1; bit_sel = ~bit_sel; inv = ~iv; incl = ~ic; nocr = ~nc;
    t = 0;
    while (!done && t < 3000) begin
      if (t == busy_start_at) begin start = 1; start_vl = VW'(3); end
      else start = 0;
      @(negedge clk);
      t++;
    end
    start = 0;
    check(done == 1'b1, tag, "done reached", int'(done), 1);
    check(int'(new_vl) == expv, tag, "new VL", int'(new_vl), expv);
    check(wlog.size() == expv, tag, "written element count", wlog.size(), expv);
    seq = 1;
    foreach (wlog[i]) if (wlog[i] != i) seq = 0;
    check(seq, "R1", "ascending write indices", seq, 1);
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", int'(done), 0);
    check(int'(new_vl) == expv, "R9", "new VL held", int'(new_vl), expv);
    repeat (3) @(negedge clk);
    check(wlog.size() == expv, "R3", "no write after end", wlog.size(), expv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fill(4'b0000);
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_en && !elem_req && new_vl == '0, "R11", "outputs in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !wr_en && !elem_req && new_vl == '0, "R11", "outputs after reset", int'(busy), 0);

    fill(4'b0001);
    run("R7", 5, 0, 0, 0, 0, -1);

    fill(4'b0010); cond_tab[3] = 4'b1101;
    run("R4", 8, 1, 0, 0, 0, -1);

    fill(4'b0000); cond_tab[2] = 4'b1000;
    run("R2", 6, 3, 1, 0, 0, -1);

    fill(4'b0101); cond_tab[4] = 4'b0001; cond_tab[6] = 4'b0100;
    run("R5", 9, 0, 0, 1, 1, -1);
    run("R8", 9, 0, 0, 1, 0, -1);

    fill(4'b0001); cond_tab[0] = 4'b0000;
    run("R6", 4, 0, 0, 0, 0, -1);
    run("R6", 0, 0, 0, 0, 0, -1);

    fill(4'b0001);
    run("R7", 1, 0, 0, 0, 0, -1);

    stall_en = 1;
    fill(4'b0100); cond_tab[100] = 4'b0000;
    run("R3", 127, 2, 0, 0, 0, 10);

    fill(4'b1111);
    run("R10", 10, 1, 0, 0, 0, 5);

    fill(4'b0100); cond_tab[6] = 4'b0000;
    run("R5", 7, 3, 0, 1, 1, -1);

    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 128; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cond_tab[i] = (lfsr[3:0] == 4'd0) ? 4'b0000 : 4'b1111;
      end
      run("R2", 20 + k * 10, k % 4, 0, k[0], k[1], -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule